// File: doc/BRIEF.md
# Display Controller Register Interface

This block is the register slave of a framebuffer display controller. A simple APB-style port reaches a 4 KB window in which software sets four timing words, the base addresses of the upper and lower panel halves, a control word, an interrupt mask and a raw interrupt status that is cleared by writing ones. The top of the window returns eight read-only identification bytes, one per word. A 512-byte span inside the window is not stored here: accesses to it are passed straight to a separate palette block.

From the stored words the block continuously decodes what the rest of the controller needs. It derives the active column and row counts from packed timing fields and the enable, pixel-depth and byte/pixel ordering flags from the control word. It also drives an interrupt line from the masked status and a one-cycle invalidate pulse after every completed write, so a display pipeline knows to redraw. A `VARIANT` parameter selects the identification sequence and whether the control and mask words trade their word offsets.

Transfers are tracked by a three-state machine. `IDLE` moves to `SETUP` when select rises without enable. `SETUP` stays put while select is held without enable, returns to `IDLE` if select drops, and moves to `ACCESS` when enable rises (the commit transition, when a write takes effect). `ACCESS` returns to `SETUP` for a back-to-back transfer (select held, enable low), otherwise to `IDLE`.

Top module: `dispctl_regs`

## Requirements
- R1: After reset every stored word and the status are zero, so `cols` is 16, `rows` is 1, and `irq`, `invalidate`, `disp_en` are 0.
- R2: Word offsets 0 to 3 (byte 0x00 to 0x0C) hold timing words 0 to 3, offset 4 the upper panel base and offset 5 the lower panel base, all 32 bits, readable back; offsets 11 and 12 read the upper and lower base again. The bases also appear on `upbase` and `lpbase`.
- R3: With `VARIANT` 0, word offset 6 is the interrupt mask (low `IRQ_W` bits kept, rest read as zero) and offset 7 the full 32-bit control word; with any other `VARIANT` the two offsets are exchanged for reads and writes.
- R4: Word offset 8 reads the raw status, offset 9 the raw status ANDed with the mask, both zero-extended.
- R5: A high bit of `int_set` sets that status bit at the next edge; writing offset 10 clears each status bit whose written bit is 1, and a set in the same cycle wins over the clear.
- R6: `irq` is 1 exactly when some status bit and its mask bit are both 1.
- R7: `cols` equals ((timing0 & 0xFC) + 4) * 4 and `rows` equals (timing1 & 0x3FF) + 1.
- R8: `disp_en` is 1 only when control bits 0 and 11 are both 1; `depth` is control bits [3:1]; `bgr`, `be_byte`, `be_pixel` are control bits 8, 9 and 10.
- R9: `invalidate` is high for exactly the one cycle after each completed write, whatever its address.
- R10: For byte addresses 0x200 to 0x3FF, `pal_wr` is high during the access phase of a write with `pal_idx` = address bits [8:2] and `pal_wdata` = the write data; reads there return `pal_rdata`, and no stored word changes.
- R11: Byte addresses 0xFE0 to 0xFFF read identification byte (address - 0xFE0) >> 2 in bits [7:0]; the sequence is 10 11 04 00 0D F0 05 B1 (hex) for `VARIANT` 0 and 1, and 11 11 24 00 0D F0 05 B1 for `VARIANT` 2; writes there are ignored.
- R12: Every other address (offsets 8, 9, 10 for writes other than 10's clear, 13 to 127, and 0x400 to 0xFDF) reads zero and writes to it change no stored word.
- R13: A write takes effect only on the `SETUP` to `ACCESS` transition; select held with enable low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Transfer select |
| penable | input | 1 | Access-phase enable |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while selected |
| int_set | input | IRQ_W | Status set pulses from interrupt sources |
| irq | output | 1 | OR of masked status bits |
| invalidate | output | 1 | One-cycle pulse after a write |
| pal_wr | output | 1 | Palette write strobe |
| pal_idx | output | 7 | Palette word index |
| pal_wdata | output | 32 | Palette write data |
| pal_rdata | input | 32 | Palette read data |
| upbase | output | 32 | Upper panel base address |
| lpbase | output | 32 | Lower panel base address |
| disp_en | output | 1 | Display enabled and powered |
| depth | output | 3 | Pixel-depth mode |
| bgr | output | 1 | Blue/red order swap |
| be_byte | output | 1 | Big-endian byte order |
| be_pixel | output | 1 | Big-endian pixel order |
| cols | output | 11 | Active columns |
| rows | output | 11 | Active rows |

## Verification
The assertions take for granted that the bus master follows the two-phase protocol: enable never rises without a preceding setup cycle, and address, direction and data hold steady from setup through access. The one-cycle invalidate property in particular relies on every transfer spending at least one cycle in `SETUP`. The stimulus drives every transfer through a setup-then-access task that changes the bus only on falling edges, plus one deliberate setup-only transfer with enable kept low.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2
    } xfer_state_t;

    localparam int WOFF_W      = 10;
    localparam int PAL_IDX_W   = 7;
    localparam int N_TIMING    = 4;
    localparam int OFF_UPBASE  = 4;
    localparam int OFF_LPBASE  = 5;
    localparam int OFF_SLOT_A  = 6;
    localparam int OFF_SLOT_B  = 7;
    localparam int OFF_RAW     = 8;
    localparam int OFF_MASKED  = 9;
    localparam int OFF_CLEAR   = 10;
    localparam int OFF_UPCUR   = 11;
    localparam int OFF_LPCUR   = 12;

    function automatic logic [7:0] id_byte(input int variant, input logic [2:0] idx);
        logic [7:0] b;
        unique case (idx)
            3'd0: b = (variant == 2) ? 8'h11 : 8'h10;
            3'd1: b = 8'h11;
            3'd2: b = (variant == 2) ? 8'h24 : 8'h04;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/dispctl_xfer_fsm.sv
module dispctl_xfer_fsm
    import dispctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    output logic commit
);
    xfer_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (psel && !penable) state_nx = ST_SETUP;
            ST_SETUP:  if (!psel)            state_nx = ST_IDLE;
                       else if (penable)     state_nx = ST_ACCESS;
            ST_ACCESS: if (psel && !penable) state_nx = ST_SETUP;
                       else                  state_nx = ST_IDLE;
            default:                         state_nx = ST_IDLE;
        endcase
    end

    always_comb commit = (state == ST_SETUP) && psel && penable;

    assert_access_after_setup_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCESS) |-> ($past(state) == ST_SETUP));

endmodule

// File: rtl/dispctl_regbank.sv
module dispctl_regbank
    import dispctl_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IRQ_W   = 4,
    parameter int VARIANT = 0
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [WOFF_W-1:0]                woff,
    input  logic [DATA_W-1:0]                wdata,
    output logic [N_TIMING-1:0][DATA_W-1:0]  timing,
    output logic [DATA_W-1:0]                upbase,
    output logic [DATA_W-1:0]                lpbase,
    output logic [DATA_W-1:0]                ctrl,
    output logic [IRQ_W-1:0]                 mask
);
    localparam int MASK_OFF = (VARIANT == 0) ? OFF_SLOT_A : OFF_SLOT_B;
    localparam int CTRL_OFF = (VARIANT == 0) ? OFF_SLOT_B : OFF_SLOT_A;

    for (genvar g = 0; g < N_TIMING; g++) begin : g_timing
        always_ff @(posedge clk) begin
            if (!rst_n)                                  timing[g] <= '0;
            else if (wr_en && woff == WOFF_W'(g))        timing[g] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upbase <= '0;
            lpbase <= '0;
            ctrl   <= '0;
            mask   <= '0;
        end else if (wr_en) begin
            if (woff == WOFF_W'(OFF_UPBASE)) upbase <= wdata;
            if (woff == WOFF_W'(OFF_LPBASE)) lpbase <= wdata;
            if (woff == WOFF_W'(CTRL_OFF))   ctrl   <= wdata;
            if (woff == WOFF_W'(MASK_OFF))   mask   <= wdata[IRQ_W-1:0];
        end
    end

    assert_ctrl_only_by_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && woff == WOFF_W'(CTRL_OFF)) |=> $stable(ctrl));

endmodule

// File: rtl/dispctl_irqstat.sv
module dispctl_irqstat #(
    parameter int IRQ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] set,
    input  logic             clr_en,
    input  logic [IRQ_W-1:0] clr_val,
    input  logic [IRQ_W-1:0] mask,
    output logic [IRQ_W-1:0] status,
    output logic             irq
);
    logic [IRQ_W-1:0] clr_bits;

    always_comb clr_bits = clr_en ? clr_val : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_bits) | set;
    end

    always_comb irq = |(status & mask);

    assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((status & $past(clr_val & ~set)) == '0));

    assert_set_sticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((status & $past(set)) == $past(set)));

endmodule

// File: rtl/dispctl_geom.sv
module dispctl_geom #(
    parameter int DATA_W = 32,
    parameter int GEO_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] timing0,
    input  logic [DATA_W-1:0] timing1,
    input  logic [DATA_W-1:0] ctrl,
    output logic [GEO_W-1:0]  cols,
    output logic [GEO_W-1:0]  rows,
    output logic              disp_en,
    output logic [2:0]        depth,
    output logic              bgr,
    output logic              be_byte,
    output logic              be_pixel
);
    always_comb begin
        cols     = (GEO_W'(timing0[7:2]) + GEO_W'(1)) << 4;
        rows     = GEO_W'(timing1[9:0]) + GEO_W'(1);
        disp_en  = ctrl[0] & ctrl[11];
        depth    = ctrl[3:1];
        bgr      = ctrl[8];
        be_byte  = ctrl[9];
        be_pixel = ctrl[10];
    end

    assert_cols_grid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cols[3:0] == 4'd0) && (cols != '0));
    assert_rows_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rows != '0);

endmodule

// File: rtl/dispctl_regs.sv
module dispctl_regs
    import dispctl_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int IRQ_W   = 4,
    parameter int GEO_W   = 11,
    parameter int VARIANT = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [ADDR_W-1:0]    paddr,
    input  logic [DATA_W-1:0]    pwdata,
    output logic [DATA_W-1:0]    prdata,
    input  logic [IRQ_W-1:0]     int_set,
    output logic                 irq,
    output logic                 invalidate,
    output logic                 pal_wr,
    output logic [PAL_IDX_W-1:0] pal_idx,
    output logic [DATA_W-1:0]    pal_wdata,
    input  logic [DATA_W-1:0]    pal_rdata,
    output logic [DATA_W-1:0]    upbase,
    output logic [DATA_W-1:0]    lpbase,
    output logic                 disp_en,
    output logic [2:0]           depth,
    output logic                 bgr,
    output logic                 be_byte,
    output logic                 be_pixel,
    output logic [GEO_W-1:0]     cols,
    output logic [GEO_W-1:0]     rows
);
    localparam int MASK_OFF = (VARIANT == 0) ? OFF_SLOT_A : OFF_SLOT_B;

    logic                            commit, wr_commit;
    logic                            in_pal, in_id, in_reg;
    logic [WOFF_W-1:0]               woff;
    logic [N_TIMING-1:0][DATA_W-1:0] timing;
    logic [DATA_W-1:0]               ctrl;
    logic [IRQ_W-1:0]                mask, status;

    always_comb begin
        woff      = paddr[WOFF_W+1:2];
        in_pal    = (paddr[ADDR_W-1:9] == 3'b001);
        in_id     = (paddr[ADDR_W-1:5] == 7'h7F);
        in_reg    = (paddr[ADDR_W-1:9] == 3'b000);
        wr_commit = commit && pwrite;
        pal_wr    = wr_commit && in_pal;
        pal_idx   = paddr[8:2];
        pal_wdata = pwdata;
    end

    dispctl_xfer_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .commit(commit)
    );

    dispctl_regbank #(.DATA_W(DATA_W), .IRQ_W(IRQ_W), .VARIANT(VARIANT)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_commit && in_reg), .woff(woff),
        .wdata(pwdata), .timing(timing), .upbase(upbase), .lpbase(lpbase),
        .ctrl(ctrl), .mask(mask)
    );

    dispctl_irqstat #(.IRQ_W(IRQ_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .set(int_set),
        .clr_en(wr_commit && in_reg && woff == WOFF_W'(OFF_CLEAR)),
        .clr_val(pwdata[IRQ_W-1:0]), .mask(mask), .status(status), .irq(irq)
    );

    dispctl_geom #(.DATA_W(DATA_W), .GEO_W(GEO_W)) u_geom (
        .clk(clk), .rst_n(rst_n), .timing0(timing[0]), .timing1(timing[1]),
        .ctrl(ctrl), .cols(cols), .rows(rows), .disp_en(disp_en), .depth(depth),
        .bgr(bgr), .be_byte(be_byte), .be_pixel(be_pixel)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) invalidate <= 1'b0;
        else        invalidate <= wr_commit;
    end

    always_comb begin
        prdata = '0;
        if (in_id) begin
            prdata = DATA_W'(id_byte(VARIANT, paddr[4:2]));
        end else if (in_pal) begin
            prdata = pal_rdata;
        end else if (in_reg) begin
            if (woff < WOFF_W'(N_TIMING))
                prdata = timing[woff[1:0]];
            else if (woff == WOFF_W'(OFF_UPBASE) || woff == WOFF_W'(OFF_UPCUR))
                prdata = upbase;
            else if (woff == WOFF_W'(OFF_LPBASE) || woff == WOFF_W'(OFF_LPCUR))
                prdata = lpbase;
            else if (woff == WOFF_W'(MASK_OFF))
                prdata = DATA_W'(mask);
            else if (woff == WOFF_W'(OFF_SLOT_A) || woff == WOFF_W'(OFF_SLOT_B))
                prdata = ctrl;
            else if (woff == WOFF_W'(OFF_RAW))
                prdata = DATA_W'(status);
            else if (woff == WOFF_W'(OFF_MASKED))
                prdata = DATA_W'(status & mask);
        end
    end

    assert_invalidate_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate |-> $past(psel && penable && pwrite));
    assert_invalidate_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate |=> !invalidate);
    assert_enable_needs_power_R8: assert property (@(posedge clk) disable iff (!rst_n)
        disp_en |-> (ctrl[0] && ctrl[11]));
    assert_palette_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pal_wr |-> (psel && penable && pwrite && paddr >= ADDR_W'(12'h200) && paddr < ADDR_W'(12'h400)));

endmodule

// File: tb/sim_dispctl_regs.sv
module sim_dispctl_regs;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic psel = 0, penable = 0, pwrite = 0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [3:0]  int_set = '0;
    logic [31:0] pal_rdata = 32'hC0FFEE01;

    logic [31:0] prdata0, prdata1, upbase, lpbase, pal_wdata, up1, lp1, pw1;
    logic irq, invalidate, pal_wr, disp_en, bgr, be_byte, be_pixel;
    logic irq1, inv1, pwr1, en1, bgr1, bb1, bp1;
    logic [6:0] pal_idx, pi1;
    logic [2:0] depth, d1;
    logic [10:0] cols, rows, c1, r1;

    int checks = 0, fails = 0;
    bit done = 0;
    logic inv_seen, palwr_seen;
    logic [6:0] palidx_seen;
    logic [31:0] palwd_seen;

    always #10 clk = ~clk;

    dispctl_regs #(.VARIANT(0)) u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata0), .int_set(int_set),
        .irq(irq), .invalidate(invalidate), .pal_wr(pal_wr), .pal_idx(pal_idx),
        .pal_wdata(pal_wdata), .pal_rdata(pal_rdata), .upbase(upbase), .lpbase(lpbase),
        .disp_en(disp_en), .depth(depth), .bgr(bgr), .be_byte(be_byte),
        .be_pixel(be_pixel), .cols(cols), .rows(rows)
    );

    dispctl_regs #(.VARIANT(2)) u1 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata1), .int_set(int_set),
        .irq(irq1), .invalidate(inv1), .pal_wr(pwr1), .pal_idx(pi1),
        .pal_wdata(pw1), .pal_rdata(pal_rdata), .upbase(up1), .lpbase(lp1),
        .disp_en(en1), .depth(d1), .bgr(bgr1), .be_byte(bb1),
        .be_pixel(bp1), .cols(c1), .rows(r1)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        #1 palwr_seen = pal_wr; palidx_seen = pal_idx; palwd_seen = pal_wdata;
        @(negedge clk); inv_seen = invalidate; psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d0, output logic [31:0] d1);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1;
        #1 d0 = prdata0; d1 = prdata1;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    function automatic logic [7:0] exp_id(input int v, input int i);
        logic [7:0] t [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        if (v == 2 && i == 0) return 8'h11;
        if (v == 2 && i == 2) return 8'h24;
        return t[i];
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic [31:0] a, b;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cols", 32'(cols), 32'd16);
        chk("R1 rows", 32'(rows), 32'd1);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 invalidate", 32'(invalidate), 0);
        chk("R1 disp_en", 32'(disp_en), 0);
        rd(12'h010, a, b); chk("R1 upbase", a, 0);

        // R2 storage and mirrors
        for (int i = 0; i < 6; i++) wr(12'(i * 4), 32'hA5000000 + 32'(i * 32'h01010101));
        for (int i = 0; i < 6; i++) begin
            rd(12'(i * 4), a, b);
            chk("R2 readback", a, 32'hA5000000 + 32'(i * 32'h01010101));
        end
        rd(12'h02C, a, b); chk("R2 upcur", a, 32'hA5000000 + 32'h04040404);
        rd(12'h030, a, b); chk("R2 lpcur", a, 32'hA5000000 + 32'h05050505);
        chk("R2 upbase port", upbase, 32'hA5000000 + 32'h04040404);
        chk("R2 lpbase port", lpbase, 32'hA5000000 + 32'h05050505);

        // R9 invalidate after write
        wr(12'h008, 32'h1234); chk("R9 invalidate pulse", 32'(inv_seen), 1);
        @(negedge clk); chk("R9 invalidate single", 32'(invalidate), 0);

        // R3 variant swap
        wr(12'h018, 32'h00000009);
        wr(12'h01C, 32'h00000803);
        rd(12'h018, a, b); chk("R3 v0 off6 mask", a, 32'h9); chk("R3 v2 off6 ctrl", b, 32'h9);
        rd(12'h01C, a, b); chk("R3 v0 off7 ctrl", a, 32'h803); chk("R3 v2 off7 mask", b, 32'h3);
        chk("R3 v0 en", 32'(disp_en), 1); chk("R3 v2 en", 32'(en1), 0);
        chk("R3 v2 depth", 32'(d1), 4);

        // R8 control decode sweep
        for (int e = 0; e < 4; e++)
            for (int k = 0; k < 8; k++)
                for (int d = 0; d < 8; d++) begin
                    logic [31:0] v;
                    v = (32'(e >> 1) << 11) | (32'(k) << 8) | (32'(d) << 1) | 32'(e & 1);
                    wr(12'h01C, v);
                    chk("R8 en", 32'(disp_en), 32'(e == 3));
                    chk("R8 depth", 32'(depth), 32'(d));
                    chk("R8 order", {29'd0, be_pixel, be_byte, bgr}, 32'(k));
                end

        // R7 geometry sweeps
        for (int t = 0; t < 256; t++) begin
            wr(12'h000, 32'hFFFFFF00 | 32'(t));
            chk("R7 cols", 32'(cols), ((32'(t) & 32'hFC) + 4) * 4);
        end
        for (int t = 0; t < 1024; t++) begin
            wr(12'h004, 32'hFFFFFC00 | 32'(t));
            chk("R7 rows", 32'(rows), 32'(t) + 1);
        end

        // R4 R5 R6 interrupt status
        wr(12'h028, 32'hF);
        @(negedge clk); int_set = 4'hB; @(negedge clk); int_set = 0;
        wr(12'h018, 32'h3);
        rd(12'h020, a, b); chk("R4 raw", a, 32'hB);
        rd(12'h024, a, b); chk("R4 masked", a, 32'h3);
        chk("R6 irq high", 32'(irq), 1);
        wr(12'h028, 32'h3);
        rd(12'h020, a, b); chk("R5 w1c", a, 32'h8);
        chk("R6 irq low", 32'(irq), 0);
        int_set = 4'h1;
        wr(12'h028, 32'hF);
        int_set = 0;
        rd(12'h020, a, b); chk("R5 set wins", a, 32'h1);
        chk("R6 irq set", 32'(irq), 1);

        // R10 palette window
        wr(12'h000, 32'h0000002C);
        wr(12'h3F4, 32'hDEADBEEF);
        chk("R10 pal_wr", 32'(palwr_seen), 1);
        chk("R10 pal_idx", 32'(palidx_seen), 32'h7D);
        chk("R10 pal_wdata", palwd_seen, 32'hDEADBEEF);
        rd(12'h200, a, b); chk("R10 pal read", a, 32'hC0FFEE01);
        rd(12'h000, a, b); chk("R10 regs untouched", a, 32'h0000002C);
        wr(12'h020, 32'h0); chk("R10 no strobe outside", 32'(palwr_seen), 0);

        // R11 identification
        for (int i = 0; i < 8; i++) begin
            rd(12'hFE0 + 12'(i * 4), a, b);
            chk("R11 id v0", a, 32'(exp_id(0, i)));
            chk("R11 id v2", b, 32'(exp_id(2, i)));
        end
        wr(12'hFE0, 32'hFFFFFFFF);
        rd(12'hFE0, a, b); chk("R11 id write ignored", a, 32'h10);

        // R12 unmapped
        for (int w = 13; w < 128; w++) begin
            rd(12'(w * 4), a, b); chk("R12 unmapped zero", a, 0);
        end
        for (int w = 256; w < 1016; w++) begin
            rd(12'(w * 4), a, b); chk("R12 unmapped zero", a, 0);
        end
        rd(12'h028, a, b); chk("R12 clear reads zero", a, 0);
        wr(12'h020, 32'hFFFFFFFF); wr(12'h024, 32'hFFFFFFFF);
        wr(12'h034, 32'hFFFFFFFF); wr(12'h400, 32'hFFFFFFFF);
        rd(12'h000, a, b); chk("R12 timing0 kept", a, 32'h0000002C);
        rd(12'h020, a, b); chk("R12 status kept", a, 32'h1);
        rd(12'h018, a, b); chk("R12 mask kept", a, 32'h3);
        chk("R12 cols kept", 32'(cols), 32'd192);

        // R13 setup without enable
        @(negedge clk); psel = 1; pwrite = 1; paddr = 12'h010; pwdata = 32'h55AA55AA;
        @(negedge clk); @(negedge clk);
        chk("R13 no invalidate", 32'(invalidate), 0);
        psel = 0; pwrite = 0;
        rd(12'h010, a, b); chk("R13 upbase kept", a, 32'hA5000000 + 32'h04040404);

        summary();
    end
endmodule